// File: doc/BRIEF.md
# Pixel Rectangle Transfer Engine

This engine copies a rectangular region of 16-bit pixels between a 32-bit word stream and a two-dimensional frame memory. The default memory is 1024 pixels wide and 512 lines tall. A transfer is armed with two control words. The first gives the top-left corner and the second gives the width and height. A direction bit selects one of two modes:

- **Write mode:** stream words are unpacked into memory writes.
- **Read mode:** each data request is answered with two pixels fetched from memory.

Every stream word holds two pixels, and the pixel in the low half comes first. The engine keeps its own cursor: the current line, the column offset inside that line, and the count of lines still to go. Because of this, the stream may deliver or request words at any pace, with gaps of any length. A word may also straddle the end of one line and the start of the next.

The frame memory sits outside the block. The block drives a pixel address, write and read strobes, and write data. It takes read data one clock after a read strobe. Column positions wrap around the memory width and line positions wrap around its height.

Top module: `rvx_rect_xfer`

## Requirements
- R1: The start column is the low X_BITS bits of the position word (10 by default). The start line is the Y_BITS bits starting at position bit 16 (9 by default). The width is size bits 15:0 and the height is size bits 31:16. All other position bits are ignored. The pixel address is line * 2^X_BITS + column.
- R2: In write mode, bits 15:0 of an accepted stream word are written to the current cursor pixel, and bits 31:16 are written to the pixel after it.
- R3: After the last pixel of a line, the column offset returns to zero, the line advances by one, and the remaining height drops by one.
- R4: The line number wraps to zero after line 2^Y_BITS - 1.
- R5: The column (start column plus offset) wraps modulo 2^X_BITS within a line.
- R6: Idle gaps between stream words do not disturb the cursor. A transfer resumes exactly where it stopped, including in the middle of a line.
- R7: In read mode, an accepted rd_req returns one word on rd_data with a one-cycle rd_valid pulse. The next pixel is in bits 15:0 and the one after it is in bits 31:16. rd_valid rises on the fourth falling clock edge after the accepting rising edge.
- R8: busy is high while lines remain. It falls in the cycle after the final pixel's memory access. If the transfer ends on the low half of a word, the high half is not written, and on a read it returns as zero.
- R9: A start with zero width or zero height never raises busy and makes no memory access.
- R10: img_ready is set by a read-mode start and cleared by a write-mode start.
- R11: After reset, busy, wr_ready, rd_ready, rd_valid, mem_we, mem_re and img_ready are all 0.
- R12: A start while a transfer is active abandons the old transfer. The new rectangle is loaded, and the remaining pixels of the old transfer are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Load a new transfer from pos_word and size_word |
| xfer_read | input | 1 | Direction for the start: 1 read, 0 write |
| pos_word | input | 32 | Corner position word |
| size_word | input | 32 | Width (low half) and height (high half) |
| wr_valid | input | 1 | Stream word offered for writing |
| wr_data | input | 32 | Stream word, first pixel in the low half |
| wr_ready | output | 1 | Engine can take a stream word |
| rd_req | input | 1 | Request the next two pixels |
| rd_ready | output | 1 | Engine can accept a read request |
| rd_data | output | 32 | Returned pixel pair |
| rd_valid | output | 1 | rd_data holds a fresh pair |
| mem_addr | output | X_BITS+Y_BITS | Pixel address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 16 | Pixel to write |
| mem_rdata | input | 16 | Pixel read, valid one clock after mem_re |
| busy | output | 1 | Lines remain in the transfer |
| img_ready | output | 1 | Current transfer is a read |

## Verification
The bench builds the engine with X_BITS=6 and Y_BITS=4, which gives a 64 by 16 pixel memory. At that size a bench RAM can be cleared and compared in full after every transfer. Rectangles placed near the right and bottom edges reach both wrap-arounds with only a few words of traffic. Odd widths make words that straddle two lines, and odd pixel totals leave a final half word that must be dropped. Each rectangle is written with uneven gaps and then read back.

// File: rtl/rvx_pkg.sv
package rvx_pkg;
  localparam int WORD_W     = 32;
  localparam int PIX_W      = 16;
  localparam int DIM_W      = 16;
  localparam int POS_Y_LSB  = 16;
  localparam int SIZE_H_LSB = 16;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_W0,
    SQ_W1,
    SQ_R0,
    SQ_R1,
    SQ_RF
  } seq_state_e;
endpackage

// File: rtl/rvx_field_decode.sv
module rvx_field_decode
  import rvx_pkg::*;
#(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9
) (
  input  logic [WORD_W-1:0] pos_word,
  input  logic [WORD_W-1:0] size_word,
  output logic [X_BITS-1:0] col,
  output logic [Y_BITS-1:0] line,
  output logic [DIM_W-1:0]  width,
  output logic [DIM_W-1:0]  height
);
  always_comb begin
    col    = pos_word[X_BITS-1:0];
    line   = pos_word[POS_Y_LSB +: Y_BITS];
    width  = size_word[DIM_W-1:0];
    height = size_word[SIZE_H_LSB +: DIM_W];
  end
endmodule

// File: rtl/rvx_rect_walker.sv
module rvx_rect_walker
  import rvx_pkg::*;
#(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  localparam int AW = X_BITS + Y_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [X_BITS-1:0] ld_col,
  input  logic [Y_BITS-1:0] ld_line,
  input  logic [DIM_W-1:0]  ld_width,
  input  logic [DIM_W-1:0]  ld_height,
  input  logic              step,
  output logic              active,
  output logic              last,
  output logic [AW-1:0]     pix_addr
);
  logic [X_BITS-1:0] base_col;
  logic [Y_BITS-1:0] cur_line;
  logic [DIM_W-1:0]  row_len;
  logic [DIM_W-1:0]  lines_left;
  logic [DIM_W-1:0]  offset;
  logic              row_end;
  logic [X_BITS-1:0] cur_col;

  always_comb begin
    row_end  = ({1'b0, offset} + 17'd1) == {1'b0, row_len};
    active   = lines_left != '0;
    last     = row_end && (lines_left == DIM_W'(1));
    cur_col  = base_col + offset[X_BITS-1:0];
    pix_addr = {cur_line, cur_col};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_col   <= '0;
      cur_line   <= '0;
      row_len    <= '0;
      lines_left <= '0;
      offset     <= '0;
    end else if (load) begin
      base_col   <= ld_col;
      cur_line   <= ld_line;
      row_len    <= ld_width;
      lines_left <= (ld_width == '0) ? '0 : ld_height;
      offset     <= '0;
    end else if (step && active) begin
      if (row_end) begin
        offset     <= '0;
        cur_line   <= cur_line + 1'b1;
        lines_left <= lines_left - 1'b1;
      end else begin
        offset <= offset + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rvx_pixel_seq.sv
module rvx_pixel_seq
  import rvx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_read,
  input  logic              active,
  input  logic              last,
  output logic              step,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_req,
  output logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              mem_we,
  output logic              mem_re,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              img_ready
);
  seq_state_e        st;
  logic              dir_rd;
  logic              hi_ok;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    wr_ready  = active && !dir_rd && (st == SQ_IDLE);
    rd_ready  = active &&  dir_rd && (st == SQ_IDLE);
    mem_we    = (st == SQ_W0) || (st == SQ_W1);
    mem_re    = (st == SQ_R0) || ((st == SQ_R1) && hi_ok);
    mem_wdata = (st == SQ_W1) ? word_q[WORD_W-1:PIX_W] : word_q[PIX_W-1:0];
    step      = mem_we || mem_re;
    img_ready = dir_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      dir_rd   <= 1'b0;
      hi_ok    <= 1'b0;
      word_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (start) begin
      st       <= SQ_IDLE;
      dir_rd   <= start_read;
      hi_ok    <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (wr_valid && wr_ready) begin
            word_q <= wr_data;
            st     <= SQ_W0;
          end else if (rd_req && rd_ready) begin
            st <= SQ_R0;
          end
        end
        SQ_W0: st <= last ? SQ_IDLE : SQ_W1;
        SQ_W1: st <= SQ_IDLE;
        SQ_R0: begin
          hi_ok <= !last;
          st    <= SQ_R1;
        end
        SQ_R1: begin
          word_q[PIX_W-1:0] <= mem_rdata;
          st                <= SQ_RF;
        end
        SQ_RF: begin
          rd_data  <= {(hi_ok ? mem_rdata : {PIX_W{1'b0}}), word_q[PIX_W-1:0]};
          rd_valid <= 1'b1;
          st       <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rvx_rect_xfer.sv
module rvx_rect_xfer
  import rvx_pkg::*;
#(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  localparam int AW = X_BITS + Y_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_start,
  input  logic              xfer_read,
  input  logic [WORD_W-1:0] pos_word,
  input  logic [WORD_W-1:0] size_word,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_req,
  output logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              busy,
  output logic              img_ready
);
  logic [X_BITS-1:0] dec_col;
  logic [Y_BITS-1:0] dec_line;
  logic [DIM_W-1:0]  dec_w;
  logic [DIM_W-1:0]  dec_h;
  logic              cur_active;
  logic              cur_last;
  logic              cur_step;

  rvx_field_decode #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_dec (
    .pos_word  (pos_word),
    .size_word (size_word),
    .col       (dec_col),
    .line      (dec_line),
    .width     (dec_w),
    .height    (dec_h)
  );

  rvx_rect_walker #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .load      (xfer_start),
    .ld_col    (dec_col),
    .ld_line   (dec_line),
    .ld_width  (dec_w),
    .ld_height (dec_h),
    .step      (cur_step),
    .active    (cur_active),
    .last      (cur_last),
    .pix_addr  (mem_addr)
  );

  rvx_pixel_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (xfer_start),
    .start_read (xfer_read),
    .active     (cur_active),
    .last       (cur_last),
    .step       (cur_step),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .rd_req     (rd_req),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .img_ready  (img_ready)
  );

  assign busy = cur_active;
endmodule

// File: rtl/rvx_rect_xfer_chk.sv
module rvx_rect_xfer_chk (
  input logic        clk,
  input logic        rst,
  input logic        xfer_start,
  input logic [31:0] size_word,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        rd_valid,
  input logic        mem_we,
  input logic        mem_re,
  input logic        busy,
  input logic        img_ready
);
  a_r8_access_needs_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> busy);

  a_r2_write_only_in_write_mode: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !img_ready);

  a_r7_read_only_in_read_mode: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> img_ready);

  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  a_r3_accept_gives_write: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && !xfer_start) |=> mem_we);

  a_r7_valid_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r9_zero_dims_idle: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && (size_word[15:0] == 16'd0 || size_word[31:16] == 16'd0)) |=> !busy);

  a_r8_fall_after_access: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(xfer_start)) |-> $past(mem_we || mem_re));

  a_r12_start_clears_valid: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !rd_valid);
endmodule

bind rvx_rect_xfer rvx_rect_xfer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .xfer_start (xfer_start),
  .size_word  (size_word),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .rd_valid   (rd_valid),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .busy       (busy),
  .img_ready  (img_ready)
);

// File: tb/tb_rvx_rect_xfer.sv
module tb_rvx_rect_xfer;
  localparam int XB = 6;
  localparam int YB = 4;
  localparam int AW = XB + YB;
  localparam int MW = 1 << XB;
  localparam int MH = 1 << YB;
  localparam int NPIX = MW * MH;
  localparam int NVEC = 6;
  // {pos_word, size_word}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0001_0002, 32'h0002_0004},
    {32'hFFF3_FFFC, 32'h0003_0007},
    {32'h000E_000A, 32'h0004_0005},
    {32'h0000_0000, 32'h0003_0001},
    {32'h0005_0014, 32'h0001_0003},
    {32'h0007_0028, 32'h0002_0010}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_start = 1'b0, xfer_read = 1'b0;
  logic [31:0]   pos_word = '0, size_word = '0;
  logic          wr_valid = 1'b0, rd_req = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          wr_ready, rd_ready, rd_valid, mem_we, mem_re, busy, img_ready;
  logic [31:0]   rd_data;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata, mem_rdata;

  logic [15:0]   ram [NPIX];
  logic [15:0]   model [NPIX];
  logic [AW-1:0] clr_ptr = '0;
  int            checks = 0, fails = 0;

  always #4 clk = ~clk;

  rvx_rect_xfer #(.X_BITS(XB), .Y_BITS(YB)) dut (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_read(xfer_read),
    .pos_word(pos_word), .size_word(size_word), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_req(rd_req),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
    .img_ready(img_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram[clr_ptr] <= '0;
      clr_ptr      <= clr_ptr + 1'b1;
    end else if (mem_we) begin
      ram[mem_addr] <= mem_wdata;
    end
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  function automatic int pix_addr(input int x, input int y, input int w, input int k);
    return (((y + k / w) % MH) * MW) + ((x + k % w) % MW);
  endfunction

  function automatic logic [15:0] pat(input int v, input int k);
    return 16'(v * 16'h1000 + k * 3 + 16'h0101);
  endfunction

  task automatic do_start(input bit rd, input logic [31:0] p, input logic [31:0] s);
    @(negedge clk);
    xfer_start = 1'b1; xfer_read = rd; pos_word = p; size_word = s;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] d);
    int guard = 0;
    wr_valid = 1'b1; wr_data = d;
    while (!wr_ready && guard < 20) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] d, output int lat);
    int guard = 0;
    rd_req = 1'b1;
    while (!rd_ready && guard < 20) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    lat = 1;
    while (!rd_valid && lat < 10) begin @(negedge clk); lat++; end
    d = rd_data;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < NPIX; i++)
      if (ram[i] !== model[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, {16'(first), ram[first]}, {16'(first), model[first]});
  endtask

  initial begin
    for (int i = 0; i < NPIX; i++) model[i] = '0;
    repeat (NPIX + 8) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(busy == 0 && wr_ready == 0 && rd_ready == 0, "R11 idle flags", {busy, wr_ready, rd_ready}, 0);
    chk(rd_valid == 0 && mem_we == 0 && mem_re == 0 && img_ready == 0, "R11 strobes",
        {rd_valid, mem_we, mem_re, img_ready}, 0);
    cmp_mem("R11 memory cleared");

    // table walk: write each rectangle with gaps, then read it back
    for (int v = 0; v < NVEC; v++) begin
      int x, y, w, h, n, nw, cnt, lat;
      logic [31:0] d, e;
      x = int'(VEC[v][63:32] & (MW - 1));
      y = int'((VEC[v][63:32] >> 16) & (MH - 1));
      w = int'(VEC[v][15:0]);
      h = int'(VEC[v][31:16]);
      n = w * h;
      nw = (n + 1) / 2;
      do_start(1'b0, VEC[v][63:32], VEC[v][31:0]);
      chk(busy == 1 && img_ready == 0, "R8 R10 write start", {busy, img_ready}, 32'h2);
      for (int j = 0; j < nw; j++) begin
        repeat (j % 3) @(negedge clk);   // R6 gaps between words
        send_word({(2*j+1 < n) ? pat(v, 2*j+1) : 16'hDEAD, pat(v, 2*j)});
      end
      cnt = 1;
      while (busy && cnt < 10) begin @(negedge clk); cnt++; end
      chk(cnt == ((n % 2) ? 2 : 3), "R8 busy drop timing", cnt, (n % 2) ? 2 : 3);
      for (int k = 0; k < n; k++) model[pix_addr(x, y, w, k)] = pat(v, k);
      cmp_mem("R1 R2 R3 R4 R5 R6 R8 written image");
      do_start(1'b1, VEC[v][63:32], VEC[v][31:0]);
      chk(img_ready == 1, "R10 read start sets flag", img_ready, 1);
      for (int j = 0; j < nw; j++) begin
        repeat ((j + 1) % 2) @(negedge clk);
        read_word(d, lat);
        e = {(2*j+1 < n) ? pat(v, 2*j+1) : 16'h0000, pat(v, 2*j)};
        chk(d == e && lat == 4, "R7 R8 read pair", d, e);
      end
      chk(busy == 0, "R8 read done", busy, 0);
    end

    // R9 zero width and zero height
    begin
      bit seen = 0;
      do_start(1'b0, 32'h0002_0003, 32'h0003_0000);
      repeat (5) begin
        if (busy || mem_we || mem_re || wr_ready) seen = 1;
        @(negedge clk);
      end
      chk(!seen, "R9 zero width", seen, 0);
      seen = 0;
      do_start(1'b1, 32'h0002_0003, 32'h0000_0005);
      repeat (5) begin
        if (busy || mem_we || mem_re || rd_ready) seen = 1;
        @(negedge clk);
      end
      chk(!seen, "R9 zero height", seen, 0);
      cmp_mem("R9 memory untouched");
    end

    // R12 restart abandons old transfer
    do_start(1'b0, 32'h0009_001E, 32'h0004_0004);
    send_word({16'hA002, 16'hA001});
    repeat (3) @(negedge clk);
    model[9*MW + 30] = 16'hA001;
    model[9*MW + 31] = 16'hA002;
    do_start(1'b0, 32'h000C_0032, 32'h0001_0002);
    chk(img_ready == 0 && busy == 1, "R12 R10 restart loads", {img_ready, busy}, 1);
    send_word({16'hB002, 16'hB001});
    repeat (3) @(negedge clk);
    model[12*MW + 50] = 16'hB001;
    model[12*MW + 51] = 16'hB002;
    chk(busy == 0 && wr_ready == 0, "R12 new transfer done", {busy, wr_ready}, 0);
    cmp_mem("R12 old remainder not written");

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule